// File: doc/BRIEF.md
# Gated Retriggerable Pulse Generator

This block produces a pulse of a set number of clock cycles on each of its channels. The default configuration has two channels. Each channel has three asynchronous inputs: an active-low trigger, an active-high trigger and an active-low clear. The block brings all three into the clock domain through two-flop synchronizers. It finds edges by comparing each synchronized level with the level it held one cycle earlier. It then starts a pulse when an edge arrives with the right levels on the other inputs. The output is a registered complementary pair, `q` and `q_n`. Each channel holds its own 16-bit pulse length, written through a one-cycle load strobe that carries a channel index.

Each channel has a small state machine with three states. `ST_IDLE` waits for a trigger. `ST_ACTIVE` drives `q` high while a down-counter runs. `ST_CLEARED` holds the output inactive while the synchronized clear is low.

The state machine has these transitions:
- `IDLE->ACTIVE` (start) is taken on a qualifying trigger with a non-zero length.
- `ACTIVE->ACTIVE` (reload) is taken on a qualifying trigger during a pulse.
- `ACTIVE->IDLE` (expire) is taken when the counter reaches zero.
- `ANY->CLEARED` (abort) is taken while the clear is low.
- `CLEARED->IDLE` (release) is taken when the clear is released and no trigger qualifies.
- `CLEARED->ACTIVE` (release-fire) is taken when the clear release is itself a qualifying trigger.

A trigger that arrives during a pulse starts the full count again. A stream of such triggers therefore keeps the output high without a break.

Top module: `os_dual`

## Requirements
- R1: A rising edge on `trig_hi` while `trig_lo_n` is low and `clr_n` is high starts a pulse. `q` goes high after the third rising clock edge that follows the input change.
- R2: A falling edge on `trig_lo_n` while `trig_hi` is high and `clr_n` is high starts a pulse with the same three-edge latency.
- R3: A rising edge on `clr_n` (the clear is released) while `trig_lo_n` is low and `trig_hi` is high starts a pulse with the same three-edge latency.
- R4: A pulse keeps `q` high for exactly the programmed length in clock cycles. A `ld_en` strobe writes `ld_len` into the length register of channel `ld_ch` at the next clock edge. After reset every length register holds 8.
- R5: A trigger while the length is 0 produces no pulse. A zero-length trigger during a running pulse leaves that pulse unchanged.
- R6: A qualifying trigger during a pulse reloads the full length, so `q` stays high without a gap until the length has run out after the last trigger.
- R7: While the synchronized clear is low, `q` is forced low and all triggers on that channel are ignored. A clear that falls during a pulse ends it after the third clock edge.
- R8: Edges that do not qualify produce no pulse: a rising `trig_hi` while `trig_lo_n` is high, a falling `trig_lo_n` while `trig_hi` is low, a falling `trig_hi`, and a rising `trig_lo_n`. An input level held steady gives exactly one pulse.
- R9: The channels are independent. A trigger or a load on one channel never changes the output of another channel.
- R10: During and after reset `q` is low and `q_n` is high on every channel. At all times `q_n` is the bitwise complement of `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_lo_n | input | NCH | Per-channel active-low trigger (falling edge fires) |
| trig_hi | input | NCH | Per-channel active-high trigger (rising edge fires) |
| clr_n | input | NCH | Per-channel active-low clear |
| ld_en | input | 1 | One-cycle strobe that writes a pulse length |
| ld_ch | input | CHW | Index of the channel whose length is written |
| ld_len | input | LW | Pulse length in clock cycles |
| q | output | NCH | Pulse output, high while a pulse is running |
| q_n | output | NCH | Complement of `q` |

## Verification
Each of the three start methods is swept on both channels with lengths 1, 2, 3 and 7 and with the reset default. This separates the latency of the start from the width of the pulse, and shows that the other channel stays quiet. Non-qualifying edges are tried next: each is one of the qualifying patterns with the gating level flipped, so a missing gate term shows up as a false pulse. Timed patterns in the middle of a pulse then cover the remaining cases: a retrigger (the width grows by the retrigger delay), a zero-length retrigger (the width stays unchanged), a clear (the width is cut to the clear delay), and triggers held under a clear (no pulse at all).

// File: rtl/os_pkg.sv
package os_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_CLEARED = 2'd2
    } os_state_t;
endpackage

// File: rtl/os_sync.sv
module os_sync #(
    parameter int          W   = 3,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST;
            q    <= RST;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/os_trig.sv
module os_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_n_in,
    input  logic hi_in,
    input  logic clr_n_in,
    output logic fire,
    output logic clr_lvl
);
    // idle levels: {clear high, hi low, lo_n high}; reset to them so no edge appears
    localparam logic [2:0] IDLE_LVL = 3'b101;

    logic [2:0] lvl;
    logic [2:0] prev;
    logic       lo_fall;
    logic       hi_rise;
    logic       clr_rise;

    os_sync #(.W(3), .RST(IDLE_LVL)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({clr_n_in, hi_in, lo_n_in}),
        .q     (lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= IDLE_LVL;
        else        prev <= lvl;
    end

    always_comb begin
        lo_fall  = prev[0] & ~lvl[0];
        hi_rise  = ~prev[1] & lvl[1];
        clr_rise = ~prev[2] & lvl[2];
        clr_lvl  = lvl[2];
        fire     = lvl[2] & ((hi_rise & ~lvl[0])
                           | (lo_fall & lvl[1])
                           | (clr_rise & ~lvl[0] & lvl[1]));
    end

    AST_FIRE_NEEDS_CLEAR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> clr_lvl); // R7
    AST_HI_FALL_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (prev[1] && !lvl[1] && prev[0] == lvl[0] && prev[2] == lvl[2]) |-> !fire); // R8
endmodule

// File: rtl/os_chan.sv
module os_chan
    import os_pkg::*;
#(
    parameter int          LW      = 16,
    parameter logic [LW-1:0] DEF_LEN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic          clr_lvl,
    input  logic          ld,
    input  logic [LW-1:0] ld_len,
    output logic          q,
    output logic          q_n
);
    os_state_t     state, nxt;
    logic [LW-1:0] len_r;
    logic [LW-1:0] cnt;
    logic          start;

    assign start = fire && clr_lvl && (len_r != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  len_r <= DEF_LEN;
        else if (ld) len_r <= ld_len;
    end

    always_comb begin
        nxt = state;
        if (!clr_lvl) begin
            nxt = ST_CLEARED;
        end else begin
            unique case (state)
                ST_IDLE:    nxt = start ? ST_ACTIVE : ST_IDLE;
                ST_ACTIVE:  nxt = start ? ST_ACTIVE
                                : ((cnt == '0) ? ST_IDLE : ST_ACTIVE);
                ST_CLEARED: nxt = start ? ST_ACTIVE : ST_IDLE;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // down-counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              cnt <= '0;
        else if (start)                          cnt <= len_r - 1'b1;
        else if (state == ST_ACTIVE && cnt != '0) cnt <= cnt - 1'b1;
    end

    // registered complementary outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q   <= 1'b0;
            q_n <= 1'b1;
        end else begin
            q   <= (nxt == ST_ACTIVE);
            q_n <= (nxt != ST_ACTIVE);
        end
    end

    AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        q_n == ~q); // R10
    AST_CLEAR_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_lvl |=> !q); // R7
    AST_START_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && len_r != '0) |=> q); // R1
    AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && len_r == '0 && state != ST_ACTIVE) |=> !q); // R5
    AST_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && cnt == '0 && !start) |=> !q); // R4
    AST_STATE_MATCHES_Q: assert property (@(posedge clk) disable iff (!rst_n)
        q == (state == ST_ACTIVE)); // R6
endmodule

// File: rtl/os_dual.sv
module os_dual #(
    parameter int NCH     = 2,
    parameter int LW      = 16,
    parameter int DEF_LEN = 8,
    localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] trig_lo_n,
    input  logic [NCH-1:0] trig_hi,
    input  logic [NCH-1:0] clr_n,
    input  logic           ld_en,
    input  logic [CHW-1:0] ld_ch,
    input  logic [LW-1:0]  ld_len,
    output logic [NCH-1:0] q,
    output logic [NCH-1:0] q_n
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic fire;
        logic clr_lvl;
        logic ld_hit;

        assign ld_hit = ld_en && (ld_ch == CHW'(g));

        os_trig u_trig (
            .clk      (clk),
            .rst_n    (rst_n),
            .lo_n_in  (trig_lo_n[g]),
            .hi_in    (trig_hi[g]),
            .clr_n_in (clr_n[g]),
            .fire     (fire),
            .clr_lvl  (clr_lvl)
        );

        os_chan #(.LW(LW), .DEF_LEN(LW'(DEF_LEN))) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .fire    (fire),
            .clr_lvl (clr_lvl),
            .ld      (ld_hit),
            .ld_len  (ld_len),
            .q       (q[g]),
            .q_n     (q_n[g])
        );
    end
endmodule

// File: tb/sim_os_dual.sv
`timescale 1ns/1ps
module sim_os_dual;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  a_n = 2'b11;
    logic [1:0]  b = 2'b00;
    logic [1:0]  c_n = 2'b11;
    logic        ld_en = 1'b0;
    logic        ld_ch = 1'b0;
    logic [15:0] ld_len = '0;
    logic [1:0]  q, q_n;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    os_dual u0 (
        .clk(clk), .rst_n(rst_n), .trig_lo_n(a_n), .trig_hi(b), .clr_n(c_n),
        .ld_en(ld_en), .ld_ch(ld_ch), .ld_len(ld_len), .q(q), .q_n(q_n)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected <150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load(input int ch, input int len);
        @(negedge clk);
        ld_en = 1'b1; ld_ch = ch[0]; ld_len = len[15:0];
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic idle_all(input int waitn);
        a_n = 2'b11; b = 2'b00; c_n = 2'b11;
        repeat (waitn) @(negedge clk);
    endtask

    // m: 0 hi rise, 1 lo fall, 2 clear release, 3 hi rise with lo high, 4 lo fall with hi low
    // scen: 0 none, 1 retrigger at j=4, 2 clear at j=5, 3 zero-length retrigger
    task automatic run(input int ch, input int m, input int scen, input int n,
                       input int ec, input string tag);
        int first = 0, last = 0, cnt = 0, other = 0, badc = 0;
        case (m)
            0: a_n[ch] = 1'b0;
            1: b[ch] = 1'b1;
            2: begin c_n[ch] = 1'b0; a_n[ch] = 1'b0; b[ch] = 1'b1; end
            default: ;
        endcase
        repeat (5) @(negedge clk);
        case (m)
            0, 3: b[ch] = 1'b1;
            1, 4: a_n[ch] = 1'b0;
            2:    c_n[ch] = 1'b1;
            default: ;
        endcase
        for (int j = 1; j <= n; j++) begin
            @(negedge clk);
            if (q[ch]) begin
                cnt++;
                if (first == 0) first = j;
                last = j;
            end
            if (q[1-ch]) other++;
            if (q_n != ~q) badc++;
            if (scen == 1 && j == 2) b[ch] = 1'b0;
            if (scen == 1 && j == 4) b[ch] = 1'b1;
            if (scen == 2 && j == 5) c_n[ch] = 1'b0;
            if (scen == 3 && j == 2) begin b[ch] = 1'b0; ld_en = 1'b1; ld_ch = ch[0]; ld_len = '0; end
            if (scen == 3 && j == 3) ld_en = 1'b0;
            if (scen == 3 && j == 4) b[ch] = 1'b1;
        end
        chk({tag, " width"}, cnt, ec);
        if (ec > 0) begin
            chk({tag, " latency R1"}, first, 3);
            chk({tag, " no gap R6"}, last - first + 1, cnt);
        end
        chk({tag, " other channel R9"}, other, 0);
        chk({tag, " complement R10"}, badc, 0);
        idle_all(6);
    endtask

    initial begin
        int lens[4] = '{1, 2, 3, 7};
        repeat (3) @(negedge clk);
        chk("reset q R10", int'(q), 0);
        chk("reset q_n R10", int'(q_n), 3);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("after reset q R10", int'(q), 0);

        run(0, 0, 0, 20, 8, "default length R4");
        run(1, 1, 0, 20, 8, "default length R4 ch1");

        for (int ch = 0; ch < 2; ch++)
            for (int m = 0; m < 3; m++)
                for (int k = 0; k < 4; k++) begin
                    load(ch, lens[k]);
                    run(ch, m, 0, 30, lens[k],
                        (m == 0) ? "hi rise R1 R4 R8" : (m == 1) ? "lo fall R2 R4" : "clear release R3 R4");
                end

        load(0, 5);
        run(0, 3, 0, 20, 0, "hi rise with lo high R8");
        run(0, 4, 0, 20, 0, "lo fall with hi low R8");

        load(1, 0);
        run(1, 0, 0, 20, 0, "zero length R5");
        load(1, 6);
        run(1, 0, 3, 30, 6, "zero-length retrigger R5");

        load(0, 6);
        run(0, 0, 1, 30, 10, "retrigger R6");
        load(0, 20);
        run(0, 0, 2, 40, 5, "clear cuts pulse R7");

        begin
            int hits = 0;
            c_n[0] = 1'b0;
            repeat (4) @(negedge clk);
            a_n[0] = 1'b0;
            repeat (4) @(negedge clk);
            b[0] = 1'b1;
            repeat (4) @(negedge clk);
            a_n[0] = 1'b1;
            repeat (4) @(negedge clk);
            a_n[0] = 1'b0;
            b[0] = 1'b0;
            repeat (4) @(negedge clk);
            c_n[0] = 1'b1;
            for (int j = 0; j < 30; j++) begin
                @(negedge clk);
                if (q[0]) hits++;
            end
            chk("triggers ignored under clear R7", hits, 0);
            idle_all(6);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule